// File: doc/BRIEF.md
# Pin Function Multiplexer with Sleep Override

This block sits between a 32-pin bank's pads and the logic that can drive them. Each pin is driven either by the general-purpose I/O logic or by one of three peripheral functions (A, B, C). The choice is held in two independent select bit-planes. Each plane is one register with one bit per pin, and the two bits of a pin together encode its function. The output value and output-enable of the chosen source reach the pad through combinational logic.

A global sleep-force input is raised by power management while the chip is in low-power sleep. A third register, the sleep-mode register, sets per pin what the force does. A pin with its sleep-mode bit at 0 is handed to the general-purpose I/O logic while the force is high, and its wake-up detection is enabled. A pin with its sleep-mode bit at 1 keeps its normal source, and its wake-up detection stays off. When the force drops, every pin returns to the function in its select planes.

The three registers are written and read over a simple register bus. A write is a single-cycle strobe with an address and data. The read data is a combinational function of the address.

Top module: `pinmux_sleep_force`

## Requirements
- R1: After reset both select planes read 0, so every pin is general-purpose I/O. The sleep-mode register reads all ones, so no pin is forced.
- R2: A pin's function is coded as {plane B bit, plane A bit}: 00 selects general-purpose I/O, 01 selects function A, 10 selects function B and 11 selects function C. The pad output and output-enable come from the selected source.
- R3: The register bus addresses are 0 for select plane A, 1 for select plane B and 2 for the sleep-mode register. A write with reg_wr high stores reg_wdata, and reg_rdata returns the stored value. Address 3 reads 0, and a write to it changes no register.
- R4: A register write changes the pad outputs from the clock edge that stores it, and not before. A change on a source input reaches the pad in the same cycle.
- R5: While sleep_force is high, every pin whose sleep-mode bit is 0 takes its pad output and output-enable from the general-purpose I/O inputs, whatever its select bits.
- R6: While sleep_force is high, every pin whose sleep-mode bit is 1 keeps the source given by its select bits.
- R7: While sleep_force is high, wake_en for a pin is 1 exactly when its sleep-mode bit is 0.
- R8: While sleep_force is low, wake_en is 0 for every pin, and every pin follows its select bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sleep_force | input | 1 | Sleep override request |
| gpio_out | input | 32 | General-purpose I/O output values |
| gpio_oe | input | 32 | General-purpose I/O output enables |
| fa_out | input | 32 | Function A output values |
| fa_oe | input | 32 | Function A output enables |
| fb_out | input | 32 | Function B output values |
| fb_oe | input | 32 | Function B output enables |
| fc_out | input | 32 | Function C output values |
| fc_oe | input | 32 | Function C output enables |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| wake_en | output | 32 | Per-pin wake-up detection enable |

## Verification
Each source input carries a distinct bit pattern, so a wrong select or sleep-mode bit drives a pin from the wrong source. That error shows on pad_out or pad_oe in the first cycle after the register write that caused it. A corrupted sleep-mode bit also shows on wake_en as soon as sleep_force is raised, and it reads back wrong on the register bus at once. The select encoding, a partly forced bank and the release of the force are each driven with mixed per-pin patterns, so one swapped code or inverted plane changes many pins at the same time.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_A    = 2'b01,
    FN_B    = 2'b10,
    FN_C    = 2'b11
  } fn_e;

  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADR_SEL_A = 2'd0;
  localparam logic [REG_AW-1:0] ADR_SEL_B = 2'd1;
  localparam logic [REG_AW-1:0] ADR_SLEEP = 2'd2;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [NPIN-1:0]   reg_wdata,
  output logic [NPIN-1:0]   reg_rdata,
  output logic [NPIN-1:0]   sel_a,
  output logic [NPIN-1:0]   sel_b,
  output logic [NPIN-1:0]   slp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a <= '0;
      sel_b <= '0;
      slp   <= '1;
    end else if (reg_wr) begin
      case (reg_addr)
        ADR_SEL_A: sel_a <= reg_wdata;
        ADR_SEL_B: sel_b <= reg_wdata;
        ADR_SLEEP: slp   <= reg_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      ADR_SEL_A: reg_rdata = sel_a;
      ADR_SEL_B: reg_rdata = sel_b;
      ADR_SLEEP: reg_rdata = slp;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pinmux_force.sv
module pinmux_force
  import pinmux_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic                 sleep_force,
  input  logic [NPIN-1:0]      sel_a,
  input  logic [NPIN-1:0]      sel_b,
  input  logic [NPIN-1:0]      slp,
  output logic [NPIN-1:0][1:0] eff_fn,
  output logic [NPIN-1:0]      wake_en
);
  logic [NPIN-1:0] forced;

  assign forced  = {NPIN{sleep_force}} & ~slp;
  assign wake_en = forced;

  for (genvar i = 0; i < NPIN; i++) begin : g_fn
    assign eff_fn[i] = forced[i] ? FN_GPIO : {sel_b[i], sel_a[i]};
  end
endmodule

// File: rtl/pinmux_pin.sv
module pinmux_pin
  import pinmux_pkg::*;
(
  input  logic [1:0] fn,
  input  logic [3:0] src_out,
  input  logic [3:0] src_oe,
  output logic       pad_out,
  output logic       pad_oe
);
  always_comb begin
    case (fn_e'(fn))
      FN_A:    begin pad_out = src_out[1]; pad_oe = src_oe[1]; end
      FN_B:    begin pad_out = src_out[2]; pad_oe = src_oe[2]; end
      FN_C:    begin pad_out = src_out[3]; pad_oe = src_oe[3]; end
      default: begin pad_out = src_out[0]; pad_oe = src_oe[0]; end
    endcase
  end
endmodule

// File: rtl/pinmux_sleep_force.sv
module pinmux_sleep_force
  import pinmux_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [NPIN-1:0]   reg_wdata,
  output logic [NPIN-1:0]   reg_rdata,
  input  logic              sleep_force,
  input  logic [NPIN-1:0]   gpio_out,
  input  logic [NPIN-1:0]   gpio_oe,
  input  logic [NPIN-1:0]   fa_out,
  input  logic [NPIN-1:0]   fa_oe,
  input  logic [NPIN-1:0]   fb_out,
  input  logic [NPIN-1:0]   fb_oe,
  input  logic [NPIN-1:0]   fc_out,
  input  logic [NPIN-1:0]   fc_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   wake_en
);
  logic [NPIN-1:0]      sel_a_q;
  logic [NPIN-1:0]      sel_b_q;
  logic [NPIN-1:0]      slp_q;
  logic [NPIN-1:0][1:0] eff_fn;

  pinmux_regs #(.NPIN(NPIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sel_a     (sel_a_q),
    .sel_b     (sel_b_q),
    .slp       (slp_q)
  );

  pinmux_force #(.NPIN(NPIN)) u_force (
    .sleep_force (sleep_force),
    .sel_a       (sel_a_q),
    .sel_b       (sel_b_q),
    .slp         (slp_q),
    .eff_fn      (eff_fn),
    .wake_en     (wake_en)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pinmux_pin u_pin (
      .fn      (eff_fn[i]),
      .src_out ({fc_out[i], fb_out[i], fa_out[i], gpio_out[i]}),
      .src_oe  ({fc_oe[i],  fb_oe[i],  fa_oe[i],  gpio_oe[i]}),
      .pad_out (pad_out[i]),
      .pad_oe  (pad_oe[i])
    );
  end
endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk
  import pinmux_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [NPIN-1:0]   reg_wdata,
  input logic              sleep_force,
  input logic [NPIN-1:0]   sel_a,
  input logic [NPIN-1:0]   sel_b,
  input logic [NPIN-1:0]   slp,
  input logic [NPIN-1:0]   gpio_out,
  input logic [NPIN-1:0]   gpio_oe,
  input logic [NPIN-1:0]   fc_out,
  input logic [NPIN-1:0]   fc_oe,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   wake_en
);
  // R8
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_force |-> wake_en == '0);

  // R7
  wake_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_force |-> wake_en == ~slp);

  // R5
  force_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_force |-> ((pad_out ^ gpio_out) & ~slp) == '0);

  // R5
  force_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_force |-> ((pad_oe ^ gpio_oe) & ~slp) == '0);

  // R2
  func_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_force |-> ((pad_out ^ fc_out) & sel_a & sel_b) == '0);

  // R3
  wr_sel_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_SEL_A) |=> sel_a == $past(reg_wdata));

  // R3
  wr_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_SLEEP) |=> slp == $past(reg_wdata));

  // R3
  wr_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> $stable(sel_a) && $stable(sel_b) && $stable(slp));
endmodule

bind pinmux_sleep_force pinmux_chk #(.NPIN(NPIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .sleep_force (sleep_force),
  .sel_a       (sel_a_q),
  .sel_b       (sel_b_q),
  .slp         (slp_q),
  .gpio_out    (gpio_out),
  .gpio_oe     (gpio_oe),
  .fc_out      (fc_out),
  .fc_oe       (fc_oe),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .wake_en     (wake_en)
);

// File: tb/tb_pinmux_sleep_force.sv
`timescale 1ns/1ps
module tb_pinmux_sleep_force;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sleep_force = 1'b0;
  logic [31:0] gpio_out = 32'hAAAA_0001, gpio_oe = 32'h5555_FFFE;
  logic [31:0] fa_out = 32'h1234_5678, fa_oe = 32'hF00F_0FF0;
  logic [31:0] fb_out = 32'h0F0F_F0F0, fb_oe = 32'h3333_CCCC;
  logic [31:0] fc_out = 32'hC3C3_3C3C, fc_oe = 32'h9669_6996;
  logic [31:0] pad_out, pad_oe, wake_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pinmux_sleep_force dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_force(sleep_force),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .fa_out(fa_out), .fa_oe(fa_oe),
    .fb_out(fb_out), .fb_oe(fb_oe), .fc_out(fc_out), .fc_oe(fc_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .wake_en(wake_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected pad vector from the requirements: code {B,A}, forced pins use GPIO.
  function automatic logic [31:0] model(input logic want_oe, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] s, input logic f);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] c;
      c = (f && !s[i]) ? 2'b00 : {b[i], a[i]};
      case (c)
        2'b01:   r[i] = want_oe ? fa_oe[i] : fa_out[i];
        2'b10:   r[i] = want_oe ? fb_oe[i] : fb_out[i];
        2'b11:   r[i] = want_oe ? fc_oe[i] : fc_out[i];
        default: r[i] = want_oe ? gpio_oe[i] : gpio_out[i];
      endcase
    end
    return r;
  endfunction

  task automatic wr(input logic [1:0] adr, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = adr; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] adr, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = adr;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic pads_check(input string req, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] s, input logic f);
    #1;
    check({req, " out"}, pad_out, model(1'b0, a, b, s, f));
    check({req, " oe"},  pad_oe,  model(1'b1, a, b, s, f));
  endtask

  task automatic t_reset;
    rd_check("R1 sel A", 2'd0, 32'h0);
    rd_check("R1 sel B", 2'd1, 32'h0);
    rd_check("R1 sleep", 2'd2, 32'hFFFF_FFFF);
    pads_check("R1 pads gpio", 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b0);
    check("R8 wake idle at reset", wake_en, 32'h0);
  endtask

  task automatic t_encoding;
    wr(2'd0, 32'h0000_FFFF);
    // R4: write to plane B staged; pads must not move before the edge
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h00FF_00FF;
    #1 check("R4 before edge", pad_out, model(1'b0, 32'h0000_FFFF, 32'h0, 32'hFFFF_FFFF, 1'b0));
    @(negedge clk);
    reg_wr = 1'b0;
    pads_check("R2 mixed codes", 32'h0000_FFFF, 32'h00FF_00FF, 32'hFFFF_FFFF, 1'b0);
    check("R2 pin0 func C", {31'h0, pad_out[0]}, {31'h0, fc_out[0]});
    check("R2 pin16 func B", {31'h0, pad_out[16]}, {31'h0, fb_out[16]});
  endtask

  task automatic t_regs;
    rd_check("R3 sel A readback", 2'd0, 32'h0000_FFFF);
    rd_check("R3 sel B readback", 2'd1, 32'h00FF_00FF);
    wr(2'd3, 32'hDEAD_BEEF);
    rd_check("R3 hole reads zero", 2'd3, 32'h0);
    rd_check("R3 hole write no A", 2'd0, 32'h0000_FFFF);
    rd_check("R3 hole write no B", 2'd1, 32'h00FF_00FF);
    rd_check("R3 hole write no sleep", 2'd2, 32'hFFFF_FFFF);
    pads_check("R3 pads after hole", 32'h0000_FFFF, 32'h00FF_00FF, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_source_change;
    @(negedge clk);
    fc_out = ~fc_out; fa_oe = ~fa_oe;
    pads_check("R4 same-cycle source", 32'h0000_FFFF, 32'h00FF_00FF, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_force;
    wr(2'd2, 32'hF0F0_3C3C);
    rd_check("R3 sleep readback", 2'd2, 32'hF0F0_3C3C);
    check("R8 no wake without force", wake_en, 32'h0);
    @(negedge clk);
    sleep_force = 1'b1;
    pads_check("R5 R6 partial force", 32'h0000_FFFF, 32'h00FF_00FF, 32'hF0F0_3C3C, 1'b1);
    check("R7 wake mask", wake_en, 32'h0F0F_C3C3);
    check("R6 pin2 keeps C", {31'h0, pad_out[2]}, {31'h0, fc_out[2]});
    check("R5 pin0 forced gpio", {31'h0, pad_oe[0]}, {31'h0, gpio_oe[0]});
    // R4 write during force: sleep bits change on the edge
    wr(2'd2, 32'h0000_0000);
    pads_check("R5 all forced", 32'h0000_FFFF, 32'h00FF_00FF, 32'h0, 1'b1);
    check("R7 wake all", wake_en, 32'hFFFF_FFFF);
  endtask

  task automatic t_release;
    @(negedge clk);
    sleep_force = 1'b0;
    pads_check("R8 release", 32'h0000_FFFF, 32'h00FF_00FF, 32'h0, 1'b0);
    check("R8 wake clear", wake_en, 32'h0);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_encoding();
    t_regs();
    t_source_change();
    t_force();
    t_release();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule